// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host bus and a flash device core. It takes write cycles from the host, decodes the low byte of each write as a command, and decides what later reads return: array contents, the status byte, identifier data or query data. Commands that need a second cycle, such as word program, block erase, buffered program and bulk buffered programming, are tracked across writes. A confirm that does not match its setup is turned into status error bits rather than an operation.

When a sequence is complete, the block starts a write state machine. It does so through a one-cycle start pulse that carries the operation kind, a latched address, the data and a word count. The block then waits for the machine's done strobe. While an operation runs, the ready bit is low and only a short list of commands is honoured. Status reading and a suspend request are the ones honoured for program and erase. Nothing is honoured during bulk programming. The array, the algorithms and burst read timing belong to other blocks.

Top module: `flash_cmd_decoder`

## Requirements
- R1: With no operation pending, a write whose low byte is 0xFF, 0x70, 0x90 or 0x98 sets `read_mode` to 0 (array), 1 (status), 2 (identifier) or 3 (query) respectively. The mode holds until another mode command arrives. After reset the mode is 0.
- R2: Status bits 5 and 4 are sticky error bits. A write of 0x50 with no operation running clears both. Nothing else clears them, mode commands included.
- R3: A write of 0x40 followed by any write starts a word program. In the cycle after the second write, `wsm_start` is high for exactly one cycle with `wsm_op`=0, `wsm_addr` and `wsm_data` taken from that second write, and `wsm_count`=1.
- R4: A write of 0x20 followed by a write of 0xD0 starts a block erase with `wsm_op`=1 and `wsm_addr` taken from the confirm write.
- R5: If the write after 0x20 is not 0xD0, status bits 5 and 4 are both set, `read_mode` becomes 1 and no operation starts.
- R6: Each setup write (0x40, 0x20, 0xE8, 0x80) sets `read_mode` to 1. When an operation completes, the mode does not return to array on its own.
- R7: While a word program, buffered program or erase runs, only 0x70 and 0xB0 take effect. Any other write leaves `read_mode` and `status` unchanged and starts nothing.
- R8: 0xE8, then a count write N, then N data writes, then 0xD0 starts a buffered program with `wsm_op`=2, `wsm_count`=N and `wsm_addr` from the count write. N must be between 1 and 512 inclusive. A count outside that range, or a final write other than 0xD0, sets status bits 5 and 4 and sets `read_mode` to 1 without starting anything.
- R9: 0x80 followed by 0xD0 starts bulk programming with `wsm_op`=3. While it runs, every write is ignored, 0x70 and 0xB0 included. A second write other than 0xD0 sets status bits 5 and 4.
- R10: Status bit 7 reads 0 from the cycle `wsm_start` is high until the cycle after `wsm_done` is sampled, and 1 otherwise.
- R11: 0xB0 during a program or erase raises `wsm_susp_req` in the next cycle. The request holds until `wsm_susp_ack` is sampled. The ack then sets status bit 6 for an erase or bit 2 for a program. Completion clears both suspend bits.
- R12: When `wsm_done` is sampled with `wsm_fail` high, status bit 5 is set for an erase and bit 4 for any kind of program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data; low byte holds the command |
| read_mode | output | 2 | 0 array, 1 status, 2 identifier, 3 query |
| status | output | 8 | Status byte (7 ready, 6 erase suspended, 5 erase error, 4 program error, 2 program suspended) |
| wsm_start | output | 1 | One-cycle start pulse to the write state machine |
| wsm_op | output | 2 | 0 word, 1 erase, 2 buffered, 3 bulk |
| wsm_addr | output | ADDR_W | Latched operation address |
| wsm_data | output | 16 | Latched data of the starting write |
| wsm_count | output | CNT_W | Word count of the operation |
| wsm_susp_req | output | 1 | Suspend request, held until acknowledged |
| wsm_done | input | 1 | Operation finished strobe |
| wsm_fail | input | 1 | Qualifies `wsm_done` as a failure |
| wsm_susp_ack | input | 1 | Suspend acknowledge strobe |

## Verification
Every result is registered once. `read_mode` and the error bits change right after the rising edge that samples the command write. The start pulse and its fields appear after the edge that samples the completing write. The ready bit falls with the start pulse and rises after the edge that samples `wsm_done`. Suspend bits follow the edge that samples the acknowledge. The bench drives all inputs on the falling edge and compares against a behavioural model on every falling edge, so each output is judged exactly one edge after the stimulus that caused it.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY} rmode_t;
  typedef enum logic [1:0] {OP_WORD, OP_ERASE, OP_BUF, OP_BULK} op_t;
  typedef enum logic [2:0] {
    S_IDLE, S_PSET, S_ESET, S_BCNT, S_BLOAD, S_BCONF, S_XSET, S_RUN
  } seq_t;

  localparam logic [7:0] C_ARRAY  = 8'hFF;
  localparam logic [7:0] C_STATUS = 8'h70;
  localparam logic [7:0] C_IDENT  = 8'h90;
  localparam logic [7:0] C_QUERY  = 8'h98;
  localparam logic [7:0] C_CLEAR  = 8'h50;
  localparam logic [7:0] C_PROG   = 8'h40;
  localparam logic [7:0] C_ERASE  = 8'h20;
  localparam logic [7:0] C_BUFP   = 8'hE8;
  localparam logic [7:0] C_BULK   = 8'h80;
  localparam logic [7:0] C_CONF   = 8'hD0;
  localparam logic [7:0] C_SUSP   = 8'hB0;

  function automatic logic is_mode_cmd(input logic [7:0] c);
    return (c == C_ARRAY) || (c == C_STATUS) || (c == C_IDENT) || (c == C_QUERY);
  endfunction

  function automatic rmode_t mode_of(input logic [7:0] c);
    case (c)
      C_ARRAY: return RM_ARRAY;
      C_IDENT: return RM_IDENT;
      C_QUERY: return RM_QUERY;
      default: return RM_STATUS;
    endcase
  endfunction

  // Whitelist while an operation runs; bulk programming accepts nothing.
  function automatic logic run_accepts(input op_t op, input logic [7:0] c);
    return (op != OP_BULK) && ((c == C_STATUS) || (c == C_SUSP));
  endfunction

  function automatic logic count_ok(input int unsigned n, input int unsigned max);
    return (n != 0) && (n <= max);
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 23,
  parameter int BUF_MAX = 512,
  parameter int CNT_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              wsm_done,
  input  logic              wsm_susp_ack,
  output logic              wsm_start,
  output op_t               wsm_op,
  output logic [ADDR_W-1:0] wsm_addr,
  output logic [15:0]       wsm_data,
  output logic [CNT_W-1:0]  wsm_count,
  output logic              wsm_susp_req,
  output logic              running,
  output op_t               run_op,
  output logic              mode_wr,
  output rmode_t            mode_val,
  output logic              ev_seq_err,
  output logic              ev_clear,
  output logic              ev_susp_ack,
  output logic              ev_done
);

  seq_t              st, st_nxt;
  logic              start_c, susp_set;
  op_t               op_c;
  logic [ADDR_W-1:0] addr_c, b_addr;
  logic [CNT_W-1:0]  cnt_c, b_cnt, rem;
  logic [7:0]        cmd;

  assign cmd         = wr_data[7:0];
  assign running     = (st == S_RUN);
  assign ev_done     = running && wsm_done;
  assign ev_susp_ack = running && wsm_susp_req && wsm_susp_ack && !wsm_done;

  always_comb begin
    st_nxt     = st;
    start_c    = 1'b0;
    op_c       = OP_WORD;
    addr_c     = wr_addr;
    cnt_c      = CNT_W'(1);
    susp_set   = 1'b0;
    mode_wr    = 1'b0;
    mode_val   = RM_STATUS;
    ev_seq_err = 1'b0;
    ev_clear   = 1'b0;
    case (st)
      S_IDLE: if (wr_en) begin
        if (is_mode_cmd(cmd)) begin
          mode_wr  = 1'b1;
          mode_val = mode_of(cmd);
        end else begin
          case (cmd)
            C_CLEAR: ev_clear = 1'b1;
            C_PROG:  begin st_nxt = S_PSET; mode_wr = 1'b1; end
            C_ERASE: begin st_nxt = S_ESET; mode_wr = 1'b1; end
            C_BUFP:  begin st_nxt = S_BCNT; mode_wr = 1'b1; end
            C_BULK:  begin st_nxt = S_XSET; mode_wr = 1'b1; end
            default: ;
          endcase
        end
      end
      S_PSET: if (wr_en) begin
        start_c = 1'b1;
        op_c    = OP_WORD;
      end
      S_ESET: if (wr_en) begin
        if (cmd == C_CONF) begin start_c = 1'b1; op_c = OP_ERASE; end
        else ev_seq_err = 1'b1;
      end
      S_BCNT: if (wr_en) begin
        if (count_ok(int'(wr_data), BUF_MAX)) st_nxt = S_BLOAD;
        else ev_seq_err = 1'b1;
      end
      S_BLOAD: if (wr_en && rem == CNT_W'(1)) st_nxt = S_BCONF;
      S_BCONF: if (wr_en) begin
        if (cmd == C_CONF) begin
          start_c = 1'b1;
          op_c    = OP_BUF;
          addr_c  = b_addr;
          cnt_c   = b_cnt;
        end else ev_seq_err = 1'b1;
      end
      S_XSET: if (wr_en) begin
        if (cmd == C_CONF) begin start_c = 1'b1; op_c = OP_BULK; end
        else ev_seq_err = 1'b1;
      end
      S_RUN: begin
        if (wsm_done) st_nxt = S_IDLE;
        else if (wr_en && run_accepts(run_op, cmd)) begin
          if (cmd == C_STATUS) mode_wr = 1'b1;
          else susp_set = 1'b1;
        end
      end
      default: st_nxt = S_IDLE;
    endcase
    if (start_c) st_nxt = S_RUN;
    if (ev_seq_err) begin
      st_nxt  = S_IDLE;
      mode_wr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      run_op       <= OP_WORD;
      wsm_start    <= 1'b0;
      wsm_op       <= OP_WORD;
      wsm_addr     <= '0;
      wsm_data     <= '0;
      wsm_count    <= '0;
      wsm_susp_req <= 1'b0;
      b_addr       <= '0;
      b_cnt        <= '0;
      rem          <= '0;
    end else begin
      st        <= st_nxt;
      wsm_start <= start_c;
      if (start_c) begin
        run_op    <= op_c;
        wsm_op    <= op_c;
        wsm_addr  <= addr_c;
        wsm_data  <= wr_data;
        wsm_count <= cnt_c;
      end
      if (st == S_BCNT && wr_en) begin
        b_addr <= wr_addr;
        b_cnt  <= wr_data[CNT_W-1:0];
        rem    <= wr_data[CNT_W-1:0];
      end else if (st == S_BLOAD && wr_en) begin
        rem <= rem - CNT_W'(1);
      end
      if (ev_done)                      wsm_susp_req <= 1'b0;
      else if (susp_set)                wsm_susp_req <= 1'b1;
      else if (wsm_susp_ack)            wsm_susp_req <= 1'b0;
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wsm_start |=> !wsm_start); // R3
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_err |=> !wsm_start); // R5
  AST_BULK_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (running && run_op == OP_BULK && !wsm_done) |=> (running && !wsm_susp_req)); // R9
  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wsm_susp_req && !wsm_susp_ack && !wsm_done) |=> wsm_susp_req); // R11

endmodule

// File: rtl/fcd_status.sv
module fcd_status
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       running,
  input  op_t        run_op,
  input  logic       ev_clear,
  input  logic       ev_seq_err,
  input  logic       ev_done,
  input  logic       done_fail,
  input  logic       ev_susp_ack,
  output logic [7:0] status
);

  logic e_err, p_err, e_susp, p_susp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_err  <= 1'b0;
      p_err  <= 1'b0;
      e_susp <= 1'b0;
      p_susp <= 1'b0;
    end else begin
      if (ev_clear) begin
        e_err <= 1'b0;
        p_err <= 1'b0;
      end else if (ev_seq_err) begin
        e_err <= 1'b1;
        p_err <= 1'b1;
      end else if (ev_done && done_fail) begin
        if (run_op == OP_ERASE) e_err <= 1'b1;
        else                    p_err <= 1'b1;
      end
      if (ev_done) begin
        e_susp <= 1'b0;
        p_susp <= 1'b0;
      end else if (ev_susp_ack) begin
        if (run_op == OP_ERASE) e_susp <= 1'b1;
        else                    p_susp <= 1'b1;
      end
    end
  end

  assign status = {!running, e_susp, e_err, p_err, 1'b0, p_susp, 2'b00};

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !ev_clear) |=> status[5]); // R2
  AST_ERR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_err |=> (status[5] && status[4])); // R5

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 23,
  parameter int BUF_MAX = 512,
  localparam int CNT_W  = $clog2(BUF_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic [1:0]        read_mode,
  output logic [7:0]        status,
  output logic              wsm_start,
  output logic [1:0]        wsm_op,
  output logic [ADDR_W-1:0] wsm_addr,
  output logic [15:0]       wsm_data,
  output logic [CNT_W-1:0]  wsm_count,
  output logic              wsm_susp_req,
  input  logic              wsm_done,
  input  logic              wsm_fail,
  input  logic              wsm_susp_ack
);

  logic   running, mode_wr, ev_seq_err, ev_clear, ev_susp_ack, ev_done;
  op_t    run_op, op_q;
  rmode_t mode_val, mode_q;

  fcd_seq #(.ADDR_W(ADDR_W), .BUF_MAX(BUF_MAX), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wsm_done(wsm_done), .wsm_susp_ack(wsm_susp_ack),
    .wsm_start(wsm_start), .wsm_op(op_q), .wsm_addr(wsm_addr), .wsm_data(wsm_data),
    .wsm_count(wsm_count), .wsm_susp_req(wsm_susp_req),
    .running(running), .run_op(run_op), .mode_wr(mode_wr), .mode_val(mode_val),
    .ev_seq_err(ev_seq_err), .ev_clear(ev_clear), .ev_susp_ack(ev_susp_ack),
    .ev_done(ev_done)
  );

  fcd_status u_status (
    .clk(clk), .rst_n(rst_n), .running(running), .run_op(run_op),
    .ev_clear(ev_clear), .ev_seq_err(ev_seq_err), .ev_done(ev_done),
    .done_fail(wsm_fail), .ev_susp_ack(ev_susp_ack), .status(status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= RM_ARRAY;
    else if (mode_wr) mode_q <= mode_val;
  end

  assign read_mode = mode_q;
  assign wsm_op    = op_q;

  AST_START_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wsm_start |-> !status[7]); // R10
  AST_START_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wsm_start |-> (read_mode == 2'd1)); // R6

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 23;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [1:0]    read_mode;
  logic [7:0]    status;
  logic          wsm_start;
  logic [1:0]    wsm_op;
  logic [AW-1:0] wsm_addr;
  logic [15:0]   wsm_data;
  logic [CW-1:0] wsm_count;
  logic          wsm_susp_req;
  logic          wsm_done = 1'b0;
  logic          wsm_fail = 1'b0;
  logic          wsm_susp_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .read_mode(read_mode), .status(status), .wsm_start(wsm_start), .wsm_op(wsm_op),
    .wsm_addr(wsm_addr), .wsm_data(wsm_data), .wsm_count(wsm_count),
    .wsm_susp_req(wsm_susp_req), .wsm_done(wsm_done), .wsm_fail(wsm_fail),
    .wsm_susp_ack(wsm_susp_ack)
  );

  // Behavioural reference model
  int m_mode, m_phase, m_op, m_rem, m_cnt, m_bcnt, m_addr, m_baddr, m_data;
  bit m_start, m_req, m_eerr, m_perr, m_esus, m_psus;

  function automatic int m_status();
    return ((m_phase == 99) ? 0 : 128) + (m_esus ? 64 : 0) + (m_eerr ? 32 : 0) +
           (m_perr ? 16 : 0) + (m_psus ? 4 : 0);
  endfunction

  always @(posedge clk) begin
    int code;
    if (!rst_n) begin
      m_mode = 0; m_phase = 0; m_op = 0; m_rem = 0; m_cnt = 0; m_bcnt = 0;
      m_addr = 0; m_baddr = 0; m_data = 0;
      m_start = 0; m_req = 0; m_eerr = 0; m_perr = 0; m_esus = 0; m_psus = 0;
    end else begin
      m_start = 0;
      code = int'(wr_data[7:0]);
      if (m_phase == 99) begin
        if (wsm_done) begin
          if (wsm_fail) begin
            if (m_op == 1) m_eerr = 1; else m_perr = 1;
          end
          m_esus = 0; m_psus = 0; m_req = 0; m_phase = 0;
        end else begin
          if (m_req && wsm_susp_ack) begin
            if (m_op == 1) m_esus = 1; else m_psus = 1;
            m_req = 0;
          end
          if (wr_en && m_op != 3) begin
            if (code == 'h70) m_mode = 1;
            else if (code == 'hB0) m_req = 1;
          end
        end
      end else if (wr_en) begin
        bit bad;
        bad = 0;
        case (m_phase)
          0: case (code)
               'hFF: m_mode = 0;
               'h70: m_mode = 1;
               'h90: m_mode = 2;
               'h98: m_mode = 3;
               'h50: begin m_eerr = 0; m_perr = 0; end
               'h40: begin m_phase = 1; m_mode = 1; end
               'h20: begin m_phase = 2; m_mode = 1; end
               'hE8: begin m_phase = 3; m_mode = 1; end
               'h80: begin m_phase = 6; m_mode = 1; end
               default: ;
             endcase
          1: begin m_start = 1; m_op = 0; m_addr = int'(wr_addr); m_cnt = 1; end
          2: if (code == 'hD0) begin m_start = 1; m_op = 1; m_addr = int'(wr_addr); m_cnt = 1; end
             else bad = 1;
          3: if (wr_data >= 1 && wr_data <= 512) begin
               m_rem = int'(wr_data); m_bcnt = m_rem; m_baddr = int'(wr_addr); m_phase = 4;
             end else bad = 1;
          4: begin m_rem--; if (m_rem == 0) m_phase = 5; end
          5: if (code == 'hD0) begin m_start = 1; m_op = 2; m_addr = m_baddr; m_cnt = m_bcnt; end
             else bad = 1;
          6: if (code == 'hD0) begin m_start = 1; m_op = 3; m_addr = int'(wr_addr); m_cnt = 1; end
             else bad = 1;
          default: ;
        endcase
        if (m_start) begin m_phase = 99; m_data = int'(wr_data); end
        if (bad) begin m_eerr = 1; m_perr = 1; m_mode = 1; m_phase = 0; end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 read_mode vs model", int'(read_mode), m_mode);
      chk("R10 status vs model", int'(status), m_status());
      chk("R3 wsm_start vs model", int'(wsm_start), int'(m_start));
      chk("R11 wsm_susp_req vs model", int'(wsm_susp_req), int'(m_req));
      if (m_start) begin
        chk("R4 wsm_op vs model", int'(wsm_op), m_op);
        chk("R3 wsm_addr vs model", int'(wsm_addr), m_addr);
        chk("R3 wsm_data vs model", int'(wsm_data), m_data);
        chk("R8 wsm_count vs model", int'(wsm_count), m_cnt);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_op(input bit fail);
    @(negedge clk);
    wsm_done = 1'b1; wsm_fail = fail;
    @(negedge clk);
    wsm_done = 1'b0; wsm_fail = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    wsm_susp_ack = 1'b1;
    @(negedge clk);
    wsm_susp_ack = 1'b0;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode array", int'(read_mode), 0);
    chk("R10 reset ready", int'(status), 'h80);

    // R1 mode commands and persistence
    wr(0, 'h90); chk("R1 ident", int'(read_mode), 2);
    wr(0, 'h98); chk("R1 query", int'(read_mode), 3);
    wr(0, 'h70); repeat (3) @(negedge clk);
    chk("R1 status persists", int'(read_mode), 1);
    wr(0, 'hFF); chk("R1 array", int'(read_mode), 0);

    // R3 word program with suspend (R11) and whitelist (R7)
    wr(0, 'h40); chk("R6 setup to status", int'(read_mode), 1);
    wr('h123, 'hBEEF);
    chk("R3 start pulse", int'(wsm_start), 1);
    chk("R3 addr", int'(wsm_addr), 'h123);
    chk("R3 data", int'(wsm_data), 'hBEEF);
    chk("R10 busy", int'(status[7]), 0);
    wr(0, 'h90); chk("R7 ident ignored while busy", int'(read_mode), 1);
    wr(0, 'hB0); chk("R11 suspend requested", int'(wsm_susp_req), 1);
    ack(); chk("R11 program suspended bit", int'(status), 'h04);
    chk("R11 request dropped", int'(wsm_susp_req), 0);
    finish_op(0); chk("R11 cleared on done", int'(status), 'h80);
    chk("R6 no return to array", int'(read_mode), 1);

    // R4 erase, R12 failure, R2 clear
    wr(0, 'h20); wr('h4000, 'hD0);
    chk("R4 erase op", int'(wsm_op), 1);
    chk("R4 erase addr", int'(wsm_addr), 'h4000);
    finish_op(1); chk("R12 erase fail bit", int'(status), 'hA0);
    wr(0, 'h50); chk("R2 clear", int'(status), 'h80);

    // R5 bad erase confirm
    wr(0, 'hFF);
    wr(0, 'h20); wr(0, 'hFF);
    chk("R5 error bits", int'(status), 'hB0);
    chk("R5 status mode", int'(read_mode), 1);
    wr(0, 'hFF); chk("R2 sticky across mode cmd", int'(status), 'hB0);

    // R7 clear ignored while erase runs; R11 erase suspend
    wr(0, 'h20); wr('h10, 'hD0);
    wr(0, 'h50); chk("R7 clear ignored while busy", int'(status), 'h30);
    wr(0, 'hB0); ack();
    chk("R11 erase suspended bit", int'(status), 'h70);
    finish_op(0); chk("R2 errors kept after op", int'(status), 'hB0);
    wr(0, 'h50);

    // R8 buffered program
    wr('h200, 'hE8); wr('h200, 3);
    for (int i = 0; i < 3; i++) wr('h200 + i, 'h1000 + i);
    wr('h200, 'hD0);
    chk("R8 buffered op", int'(wsm_op), 2);
    chk("R8 buffered count", int'(wsm_count), 3);
    wr(0, 'h20); wr(0, 'hD0);
    chk("R7 erase ignored while buffered runs", int'(wsm_start), 0);
    finish_op(1); chk("R12 program fail bit", int'(status), 'h90);
    wr(0, 'h50);

    wr(0, 'hE8); wr(0, 513);
    chk("R8 count too large", int'(status), 'hB0);
    wr(0, 'h50);
    wr(0, 'hE8); wr(0, 0);
    chk("R8 count zero", int'(status), 'hB0);
    wr(0, 'h50);
    wr('h40, 'hE8); wr('h40, 512);
    for (int i = 0; i < 512; i++) wr('h40 + i, i);
    wr(0, 'hD0);
    chk("R8 full buffer count", int'(wsm_count), 512);
    finish_op(0);
    wr(0, 'hE8); wr(0, 1); wr(0, 'h5555); wr(0, 'h70);
    chk("R8 bad confirm", int'(status), 'hB0);
    wr(0, 'h50);

    // R9 bulk programming
    wr(0, 'h80); wr('h800, 'hD0);
    chk("R9 bulk op", int'(wsm_op), 3);
    wr(0, 'hFF); wr(0, 'hB0);
    chk("R9 mode locked", int'(read_mode), 1);
    chk("R9 suspend refused", int'(wsm_susp_req), 0);
    finish_op(0); chk("R10 ready after done", int'(status), 'h80);
    wr(0, 'h80); wr(0, 'h70);
    chk("R9 bad confirm", int'(status), 'hB0);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule